// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the 16-bit status and control word of a processor core. When an instruction completes, it takes the operands, the result and the raw carry or borrow from the arithmetic unit. From these it recomputes the six arithmetic status flags for either a byte or a word operand. A per-flag mask chooses which flags the instruction may change.

Three control flags sit in the same word: trap, interrupt enable and direction. Each has an explicit set input and an explicit clear input, and a whole-word load path restores every writable bit at once. Positions that carry no flag always read back the same fixed pattern.

Beyond the word itself, the block drives three things. It produces a one-cycle single-step trap request that fires one instruction after the trap flag comes on, and clears that flag as it fires. It gates a maskable interrupt request with the interrupt-enable flag. It supplies the signed step that string index registers add on each element.

Top module: `psw_flag_unit`

## Requirements
- R1: While and after reset, `flags_o` reads 16'h0002 (every flag clear) and `trap_req_o` is 0.
- R2: On a cycle with `done_i` high, `load_i` low and mask bit 0 set, bit 0 (carry) takes the value of `carry_i` from the next cycle on.
- R3: Under the same condition with mask bit 1, bit 2 (parity) is set exactly when `res_i[7:0]` holds an even number of ones, whatever the operand size.
- R4: With mask bit 2, bit 4 (auxiliary carry) becomes `opa_i[4]^opb_i[4]^res_i[4]`. With mask bit 3, bit 6 (zero) is set when the sized result (`res_i[7:0]` for bytes, all of `res_i` for words) is zero.
- R5: With mask bit 4, bit 7 (sign) copies the top bit of the sized result: bit 7 when `wide_i` is 0, bit 15 when it is 1.
- R6: With mask bit 5, bit 11 (overflow) is set when the signed result does not fit. For an add (`sub_i`=0) that means equal operand signs and a result sign that differs from them. For a subtract (`sub_i`=1) it means differing operand signs and a result sign that differs from `opa_i`.
- R7: A status flag keeps its value on any cycle without `done_i`, and on a `done_i` cycle whose mask bit for it is 0.
- R8: `load_i` writes every flag position of `flags_o` from `load_word_i` on the next cycle, and it wins over a status update in the same cycle.
- R9: Bits 0, 1 and 2 of `ctl_set_i` and `ctl_clr_i` act on trap (bit 8), interrupt enable (bit 9) and direction (bit 10). Clear wins over set, and both win over `load_i`.
- R10: Bit 1 always reads 1, and bits 3, 5 and 12 to 15 always read 0, even after a load.
- R11: The first `done_i` in or after the cycle in which the trap flag becomes 1 ends the setting instruction. The next `done_i` while the flag is still 1 makes `trap_req_o` high for exactly the following cycle, and in that cycle the trap flag reads 0 whatever writes came with it.
- R12: `take_irq_o` is `nmi_i | int_irq_i | (mask_irq_i & interrupt-enable flag)`, combinationally.
- R13: `dir_dec_o` equals the direction flag. `step_o` is +1 for bytes or +2 for words when it is 0, and -1 or -2 (two's complement) when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Instruction-complete strobe |
| wide_i | input | 1 | Operand size: 1 word, 0 byte |
| sub_i | input | 1 | Operation was a subtract |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand |
| res_i | input | DATA_W | Arithmetic result |
| carry_i | input | 1 | Raw carry/borrow out at the selected size |
| upd_mask_i | input | 6 | Per-flag update mask (0 carry, 1 parity, 2 aux, 3 zero, 4 sign, 5 overflow) |
| load_i | input | 1 | Whole-word load strobe |
| load_word_i | input | 16 | Word to load |
| ctl_set_i | input | 3 | Set trap / int-enable / direction |
| ctl_clr_i | input | 3 | Clear trap / int-enable / direction |
| mask_irq_i | input | 1 | Maskable external interrupt request |
| nmi_i | input | 1 | Nonmaskable interrupt request |
| int_irq_i | input | 1 | Internally generated interrupt request |
| flags_o | output | 16 | Status and control word |
| trap_req_o | output | 1 | Single-step trap request pulse |
| take_irq_o | output | 1 | Interrupt request after gating |
| dir_dec_o | output | 1 | String indices count down |
| step_o | output | DATA_W | Signed index step per string element |

## Verification
The bench builds the block with its default `DATA_W` of 16. At that width the byte sign bit (7) and the word sign bit (15) are distinct, as are the 8-bit and 16-bit carry and zero conditions. Real adds and subtracts at both sizes therefore exercise the overflow and auxiliary-carry rules at each size. Random mixes of loads, set/clear pulses and sparse completion strobes place trap-flag changes between, on and just before completions, which covers the delayed and self-clearing trap.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;

    localparam int FLAG_W = 16;
    localparam int BYTE_W = 8;
    localparam int NSTAT  = 6;
    localparam int NCTL   = 3;

    // positions inside the flag word
    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

    // operand bit whose carry-in reveals the nibble carry
    localparam int AUX_BIT = 4;

    localparam logic [FLAG_W-1:0] USED_MASK =
        FLAG_W'((1 << POS_CF) | (1 << POS_PF) | (1 << POS_AF) | (1 << POS_ZF) |
                (1 << POS_SF) | (1 << POS_TF) | (1 << POS_IF) | (1 << POS_DF) |
                (1 << POS_OF));
    localparam logic [FLAG_W-1:0] RSVD_VAL = FLAG_W'(16'h0002) & ~USED_MASK;

    // bit i of the packed struct matches update-mask bit i
    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } stat_t;

    // bit i matches set/clear input bit i
    typedef struct packed {
        logic df_f;
        logic ie_f;
        logic tf_f;
    } ctl_t;

    function automatic logic even_ones8(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic stat_t word_to_stat(input logic [FLAG_W-1:0] w);
        stat_t s;
        s.cf_f = w[POS_CF];
        s.pf_f = w[POS_PF];
        s.af_f = w[POS_AF];
        s.zf_f = w[POS_ZF];
        s.sf_f = w[POS_SF];
        s.of_f = w[POS_OF];
        return s;
    endfunction

    function automatic ctl_t word_to_ctl(input logic [FLAG_W-1:0] w);
        ctl_t c;
        c.tf_f = w[POS_TF];
        c.ie_f = w[POS_IF];
        c.df_f = w[POS_DF];
        return c;
    endfunction

    function automatic logic [FLAG_W-1:0] build_word(input stat_t s, input ctl_t c);
        logic [FLAG_W-1:0] w;
        w         = RSVD_VAL;
        w[POS_CF] = s.cf_f;
        w[POS_PF] = s.pf_f;
        w[POS_AF] = s.af_f;
        w[POS_ZF] = s.zf_f;
        w[POS_SF] = s.sf_f;
        w[POS_OF] = s.of_f;
        w[POS_TF] = c.tf_f;
        w[POS_IF] = c.ie_f;
        w[POS_DF] = c.df_f;
        return w;
    endfunction

endpackage

// File: rtl/psw_status_calc.sv
`timescale 1ns/1ps
module psw_status_calc
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              wide_i,
    input  logic              sub_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              carry_i,
    output stat_t             stat_o
);

    localparam int MSB_WORD = DATA_W - 1;
    localparam int MSB_BYTE = BYTE_W - 1;

    logic a_sgn, b_sgn, r_sgn;
    logic res_zero;
    logic unused_opnd;

    always_comb begin
        a_sgn = wide_i ? opa_i[MSB_WORD] : opa_i[MSB_BYTE];
        b_sgn = wide_i ? opb_i[MSB_WORD] : opb_i[MSB_BYTE];
        r_sgn = wide_i ? res_i[MSB_WORD] : res_i[MSB_BYTE];
        res_zero = wide_i ? (res_i == '0) : (res_i[MSB_BYTE:0] == '0);
    end

    always_comb begin
        stat_o.cf_f = carry_i;
        stat_o.pf_f = even_ones8(res_i[MSB_BYTE:0]);
        stat_o.af_f = opa_i[AUX_BIT] ^ opb_i[AUX_BIT] ^ res_i[AUX_BIT];
        stat_o.zf_f = res_zero;
        stat_o.sf_f = r_sgn;
        if (sub_i) begin
            stat_o.of_f = (a_sgn != b_sgn) && (r_sgn != a_sgn);
        end else begin
            stat_o.of_f = (a_sgn == b_sgn) && (r_sgn != a_sgn);
        end
    end

    assign unused_opnd = ^{opa_i, opb_i};

endmodule

// File: rtl/psw_ctrl_trap.sv
`timescale 1ns/1ps
module psw_ctrl_trap
    import psw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            done_i,
    input  logic            load_i,
    input  ctl_t            load_ctl_i,
    input  logic [NCTL-1:0] set_i,
    input  logic [NCTL-1:0] clr_i,
    output ctl_t            ctl_o,
    output logic            trap_req_o
);

    ctl_t            ctl_q;
    logic [NCTL-1:0] base_v;
    logic [NCTL-1:0] wr_v;
    ctl_t            ctl_d;
    logic            armed_q;
    logic            armed_d;
    logic            fire;
    logic            trap_q;

    assign base_v = load_i ? NCTL'(load_ctl_i) : NCTL'(ctl_q);

    // clear beats set, both beat the load value
    for (genvar g = 0; g < NCTL; g++) begin : g_ctl_bit
        assign wr_v[g] = clr_i[g] ? 1'b0 : (set_i[g] ? 1'b1 : base_v[g]);
    end

    // one more completion after arming with the flag still on fires the trap
    assign fire = done_i && armed_q && ctl_q.tf_f;

    always_comb begin
        ctl_d = ctl_t'(wr_v);
        if (fire) begin
            ctl_d.tf_f = 1'b0;
        end
        armed_d = ctl_d.tf_f ? (done_i || armed_q) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            armed_q <= 1'b0;
            trap_q  <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            armed_q <= armed_d;
            trap_q  <= fire;
        end
    end

    assign ctl_o      = ctl_q;
    assign trap_req_o = trap_q;

endmodule

// File: rtl/psw_irq_step.sv
`timescale 1ns/1ps
module psw_irq_step
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  ctl_t              ctl_i,
    input  logic              wide_i,
    input  logic              mask_irq_i,
    input  logic              nmi_i,
    input  logic              int_irq_i,
    output logic              take_irq_o,
    output logic              dir_dec_o,
    output logic [DATA_W-1:0] step_o
);

    localparam logic [DATA_W-1:0] STEP_BYTE = DATA_W'(1);
    localparam logic [DATA_W-1:0] STEP_WORD = DATA_W'(2);

    logic [DATA_W-1:0] mag;

    assign take_irq_o = nmi_i || int_irq_i || (mask_irq_i && ctl_i.ie_f);
    assign dir_dec_o  = ctl_i.df_f;
    assign mag        = wide_i ? STEP_WORD : STEP_BYTE;
    assign step_o     = ctl_i.df_f ? (DATA_W'(0) - mag) : mag;

endmodule

// File: rtl/psw_flag_unit.sv
`timescale 1ns/1ps
module psw_flag_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic              wide_i,
    input  logic              sub_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              carry_i,
    input  logic [5:0]        upd_mask_i,
    input  logic              load_i,
    input  logic [15:0]       load_word_i,
    input  logic [2:0]        ctl_set_i,
    input  logic [2:0]        ctl_clr_i,
    input  logic              mask_irq_i,
    input  logic              nmi_i,
    input  logic              int_irq_i,
    output logic [15:0]       flags_o,
    output logic              trap_req_o,
    output logic              take_irq_o,
    output logic              dir_dec_o,
    output logic [DATA_W-1:0] step_o
);

    stat_t             calc_s;
    logic [NSTAT-1:0]  calc_v;
    logic [NSTAT-1:0]  load_v;
    logic [NSTAT-1:0]  stat_q;
    logic [NSTAT-1:0]  stat_d;
    ctl_t              ctl_s;
    logic              unused_rsvd;

    psw_status_calc #(.DATA_W(DATA_W)) u_calc (
        .wide_i  (wide_i),
        .sub_i   (sub_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .res_i   (res_i),
        .carry_i (carry_i),
        .stat_o  (calc_s)
    );

    assign calc_v = calc_s;
    assign load_v = word_to_stat(load_word_i);

    for (genvar g = 0; g < NSTAT; g++) begin : g_stat_bit
        assign stat_d[g] = load_i ? load_v[g] :
                           ((done_i && upd_mask_i[g]) ? calc_v[g] : stat_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    psw_ctrl_trap u_ctl (
        .clk        (clk),
        .rst        (rst),
        .done_i     (done_i),
        .load_i     (load_i),
        .load_ctl_i (word_to_ctl(load_word_i)),
        .set_i      (ctl_set_i),
        .clr_i      (ctl_clr_i),
        .ctl_o      (ctl_s),
        .trap_req_o (trap_req_o)
    );

    psw_irq_step #(.DATA_W(DATA_W)) u_irq (
        .ctl_i      (ctl_s),
        .wide_i     (wide_i),
        .mask_irq_i (mask_irq_i),
        .nmi_i      (nmi_i),
        .int_irq_i  (int_irq_i),
        .take_irq_o (take_irq_o),
        .dir_dec_o  (dir_dec_o),
        .step_o     (step_o)
    );

    assign flags_o     = build_word(stat_t'(stat_q), ctl_s);
    assign unused_rsvd = ^(load_word_i & ~USED_MASK);

endmodule

// File: rtl/psw_flag_unit_chk.sv
`timescale 1ns/1ps
module psw_flag_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        done_i,
    input logic        load_i,
    input logic [5:0]  upd_mask_i,
    input logic        carry_i,
    input logic [2:0]  ctl_clr_i,
    input logic        mask_irq_i,
    input logic        nmi_i,
    input logic        int_irq_i,
    input logic [15:0] flags_o,
    input logic        trap_req_o,
    input logic        take_irq_o
);

    logic [5:0] stat_view;
    assign stat_view = {flags_o[11], flags_o[7], flags_o[6], flags_o[4], flags_o[2], flags_o[0]};

    assert_carry_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (done_i && upd_mask_i[0] && !load_i) |=> (flags_o[0] == $past(carry_i)));

    assert_status_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!done_i && !load_i) |=> $stable(stat_view));

    assert_dir_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_clr_i[2] |=> !flags_o[10]);

    assert_trap_clears_R11: assert property (@(posedge clk) disable iff (rst)
        trap_req_o |-> !flags_o[8]);

    assert_trap_single_R11: assert property (@(posedge clk) disable iff (rst)
        trap_req_o |=> !trap_req_o);

    assert_unmaskable_R12: assert property (@(posedge clk) disable iff (rst)
        (nmi_i || int_irq_i) |-> take_irq_o);

    assert_masked_R12: assert property (@(posedge clk) disable iff (rst)
        (!flags_o[9] && !nmi_i && !int_irq_i) |-> !take_irq_o);

    assert_gate_open_R12: assert property (@(posedge clk) disable iff (rst)
        (flags_o[9] && mask_irq_i) |-> take_irq_o);

endmodule

bind psw_flag_unit psw_flag_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .done_i     (done_i),
    .load_i     (load_i),
    .upd_mask_i (upd_mask_i),
    .carry_i    (carry_i),
    .ctl_clr_i  (ctl_clr_i),
    .mask_irq_i (mask_irq_i),
    .nmi_i      (nmi_i),
    .int_irq_i  (int_irq_i),
    .flags_o    (flags_o),
    .trap_req_o (trap_req_o),
    .take_irq_o (take_irq_o)
);

// File: tb/sim_psw_flag_unit.sv
`timescale 1ns/1ps
module sim_psw_flag_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        done_i = 1'b0, wide_i = 1'b0, sub_i = 1'b0, carry_i = 1'b0;
    logic [15:0] opa_i = '0, opb_i = '0, res_i = '0;
    logic [5:0]  upd_mask_i = '0;
    logic        load_i = 1'b0;
    logic [15:0] load_word_i = '0;
    logic [2:0]  ctl_set_i = '0, ctl_clr_i = '0;
    logic        mask_irq_i = 1'b0, nmi_i = 1'b0, int_irq_i = 1'b0;
    logic [15:0] flags_o;
    logic        trap_req_o, take_irq_o, dir_dec_o;
    logic [15:0] step_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference state
    logic [5:0] e_stat = '0;
    logic [2:0] e_ctl = '0;
    logic       e_arm = 1'b0;
    logic       e_trap = 1'b0;

    always #2 clk = ~clk;

    psw_flag_unit #(.DATA_W(16)) u0 (
        .clk(clk), .rst(rst), .done_i(done_i), .wide_i(wide_i), .sub_i(sub_i),
        .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i), .carry_i(carry_i),
        .upd_mask_i(upd_mask_i), .load_i(load_i), .load_word_i(load_word_i),
        .ctl_set_i(ctl_set_i), .ctl_clr_i(ctl_clr_i), .mask_irq_i(mask_irq_i),
        .nmi_i(nmi_i), .int_irq_i(int_irq_i), .flags_o(flags_o),
        .trap_req_o(trap_req_o), .take_irq_o(take_irq_o), .dir_dec_o(dir_dec_o),
        .step_o(step_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] compose(input logic [5:0] s, input logic [2:0] c);
        logic [15:0] w;
        w = 16'h0002;
        w[0] = s[0]; w[2] = s[1]; w[4] = s[2]; w[6] = s[3]; w[7] = s[4]; w[11] = s[5];
        w[8] = c[0]; w[9] = c[1]; w[10] = c[2];
        return w;
    endfunction

    function automatic logic [5:0] status_of(input logic [15:0] a, b, r, input logic c, wd, sb);
        logic as, bs, rs;
        logic [5:0] s;
        as = wd ? a[15] : a[7];
        bs = wd ? b[15] : b[7];
        rs = wd ? r[15] : r[7];
        s[0] = c;
        s[1] = ~(^r[7:0]);
        s[2] = a[4] ^ b[4] ^ r[4];
        s[3] = wd ? (r == 16'h0) : (r[7:0] == 8'h0);
        s[4] = rs;
        s[5] = sb ? ((as != bs) && (rs != as)) : ((as == bs) && (rs != as));
        return s;
    endfunction

    // drives a real add or subtract at the chosen size
    task automatic set_alu(input logic [15:0] a, b, input logic wd, sb);
        logic [16:0] wsum;
        logic [8:0]  bsum;
        opa_i = a; opb_i = b; wide_i = wd; sub_i = sb;
        if (sb) begin
            wsum = {1'b0, a} - {1'b0, b};
            bsum = {1'b0, a[7:0]} - {1'b0, b[7:0]};
        end else begin
            wsum = {1'b0, a} + {1'b0, b};
            bsum = {1'b0, a[7:0]} + {1'b0, b[7:0]};
        end
        res_i   = wsum[15:0];
        carry_i = wd ? wsum[16] : bsum[8];
    endtask

    task automatic idle_inputs();
        done_i = 0; load_i = 0; ctl_set_i = 0; ctl_clr_i = 0; upd_mask_i = 0;
        mask_irq_i = 0; nmi_i = 0; int_irq_i = 0;
    endtask

    // inputs are already driven just after a falling edge
    task automatic tick();
        logic [5:0]  ns;
        logic [5:0]  calc;
        logic [2:0]  base, nc;
        logic        fire;
        logic [15:0] exp_step;
        #1;
        chk("R12 take_irq", take_irq_o, nmi_i | int_irq_i | (mask_irq_i & e_ctl[1]));
        exp_step = wide_i ? 16'd2 : 16'd1;
        if (e_ctl[2]) exp_step = 16'd0 - exp_step;
        chk("R13 step", step_o, exp_step);
        chk("R13 dir", dir_dec_o, e_ctl[2]);
        calc = status_of(opa_i, opb_i, res_i, carry_i, wide_i, sub_i);
        if (load_i) begin
            ns = {load_word_i[11], load_word_i[7], load_word_i[6], load_word_i[4], load_word_i[2], load_word_i[0]};
            base = load_word_i[10:8];
        end else begin
            ns = e_stat;
            if (done_i) begin
                for (int i = 0; i < 6; i++) if (upd_mask_i[i]) ns[i] = calc[i];
            end
            base = e_ctl;
        end
        for (int i = 0; i < 3; i++) nc[i] = ctl_clr_i[i] ? 1'b0 : (ctl_set_i[i] ? 1'b1 : base[i]);
        fire = done_i & e_arm & e_ctl[0];
        if (fire) nc[0] = 1'b0;
        e_arm  = nc[0] ? (done_i | e_arm) : 1'b0;
        e_trap = fire;
        e_stat = ns;
        e_ctl  = nc;
        @(negedge clk);
        chk("R2 carry", flags_o[0], e_stat[0]);
        chk("R3 parity", flags_o[2], e_stat[1]);
        chk("R4 aux/zero", {flags_o[4], flags_o[6]}, {e_stat[2], e_stat[3]});
        chk("R5 sign", flags_o[7], e_stat[4]);
        chk("R6 overflow", flags_o[11], e_stat[5]);
        chk("R9 control", flags_o[10:8], e_ctl);
        chk("R10 reserved", flags_o & 16'hF02A, 16'h0002);
        chk("R11 trap_req", trap_req_o, e_trap);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1d2c);
        repeat (3) @(negedge clk);
        chk("R1 reset flags", flags_o, 16'h0002);
        chk("R1 reset trap", trap_req_o, 1'b0);
        rst = 1'b0;

        // byte 0x7F + 0x01: aux, sign and overflow set
        idle_inputs(); set_alu(16'h007F, 16'h0001, 1'b0, 1'b0);
        done_i = 1; upd_mask_i = 6'h3F;
        tick();
        chk("R6 byte overflow word", flags_o, 16'h0892);

        // word 0xFFFF + 0x0001: carry, parity, aux, zero
        idle_inputs(); set_alu(16'hFFFF, 16'h0001, 1'b1, 1'b0);
        done_i = 1; upd_mask_i = 6'h3F;
        tick();
        chk("R4 word zero word", flags_o, 16'h0057);

        // mask all zero: nothing changes
        idle_inputs(); set_alu(16'h0040, 16'h0050, 1'b1, 1'b1);
        done_i = 1; upd_mask_i = 6'h00;
        tick();
        chk("R7 masked hold", flags_o, 16'h0057);

        // no completion: nothing changes
        idle_inputs(); set_alu(16'h1234, 16'h4321, 1'b0, 1'b0);
        upd_mask_i = 6'h3F;
        tick();
        chk("R7 no strobe hold", flags_o, 16'h0057);

        // load beats update; reserved positions ignore it
        idle_inputs(); set_alu(16'h0000, 16'h0000, 1'b1, 1'b0);
        done_i = 1; upd_mask_i = 6'h3F; load_i = 1; load_word_i = 16'hFFFF;
        tick();
        chk("R8 load all ones", flags_o, 16'h0FD7);

        // clear beats set
        idle_inputs(); ctl_set_i = 3'b111; ctl_clr_i = 3'b111;
        tick();
        chk("R9 clear wins", flags_o, 16'h08D7);

        // set trap without completion, then two completions
        idle_inputs(); ctl_set_i = 3'b001;
        tick();
        idle_inputs(); done_i = 1;
        tick();
        chk("R11 no trap yet", trap_req_o, 1'b0);
        idle_inputs();
        tick();
        idle_inputs(); done_i = 1; ctl_set_i = 3'b001;
        tick();
        chk("R11 trap fired", {trap_req_o, flags_o[8]}, 2'b10);
        idle_inputs();
        tick();
        chk("R11 trap one cycle", trap_req_o, 1'b0);

        // load zero: only fixed bit remains
        idle_inputs(); load_i = 1; load_word_i = 16'h0000;
        tick();
        chk("R10 load zero", flags_o, 16'h0002);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            idle_inputs();
            set_alu(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 8) == 0) set_alu(16'h0080, 16'h0080, 1'($urandom), 1'b0);
            done_i      = (($urandom % 3) != 0);
            upd_mask_i  = 6'($urandom);
            load_i      = (($urandom % 12) == 0);
            load_word_i = 16'($urandom);
            for (int k = 0; k < 3; k++) begin
                ctl_set_i[k] = (($urandom % 7) == 0);
                ctl_clr_i[k] = (($urandom % 9) == 0);
            end
            mask_irq_i = 1'($urandom);
            nmi_i      = (($urandom % 5) == 0);
            int_irq_i  = (($urandom % 5) == 0);
            tick();
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule